// File: doc/BRIEF.md
# Reset Cause Status Register

This block is one word of a clock-and-reset management unit's register space. It keeps a sticky record of which reset sources have fired since the last full power cycle: the power-on event, the external chip reset pin, and a reset caused by the main processor's timer/watchdog running out. It also carries one read/write control bit that lets the coprocessor hold the main processor in reset. Software reads the word to find out why the chip last restarted. Reading the power-on flag together with the external-reset flag tells a cold start apart from a warm pin reset. Software then clears the record by writing zeros to the flags it has seen. No flag can be set from the bus.

The flags live in a reset domain that only the power-on reset clears, so they survive the resets they record. The control bit and the bus read path sit in the ordinary register-block reset domain. The event inputs are single-cycle pulses that are already synchronous to the register clock. Writes take effect on the clock edge at which they are presented. Read data is registered and appears one cycle after the read access.

Top module: `rcs_reset_cause`

## Requirements
- R1: After a power-on reset (por_rst_n low), a read of the register returns 0 and cpu_hold_rst is 0.
- R2: A por_evt pulse sets both the power-on flag (bit 5) and the external-reset flag (bit 4), so a read returns bits 5:4 = 11. An ext_evt pulse sets only bit 4 and leaves bit 5 at its previous value.
- R3: A wdt_evt pulse sets the watchdog flag (bit 2). An ext_evt or por_evt pulse clears bit 2. If wdt_evt arrives in the same cycle as one of those pulses, bit 2 ends at 1.
- R4: A write to the register clears each flag (bits 5, 4, 2) whose write-data bit is 0 and leaves unchanged each flag whose write-data bit is 1. A bus write never sets a flag.
- R5: If a set event and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R6: Bit 3 is read/write. cpu_hold_rst equals bit 3 (active high). Writing 1 holds the main processor in reset and writing 0 releases it.
- R7: While blk_rst_n is low, cpu_hold_rst is 0 and bit 3 is cleared. The flags keep their values through that reset.
- R8: Bits other than 5, 4, 3 and 2 read as 0 and ignore writes. Accesses to any address other than REG_OFS (default 0x18) read 0 and change nothing.
- R9: bus_rdata shows the register value one cycle after a read access (bus_sel=1, bus_wr=0) and holds it until the next read. Reads have no side effects, so repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous assert; clears the flags and the rest of the block |
| blk_rst_n | input | 1 | Register-block reset, active low; clears the hold bit and read data, leaves the flags alone |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| por_evt | input | 1 | Single-cycle pulse: power-on reset was detected |
| ext_evt | input | 1 | Single-cycle pulse: the external reset pin was asserted |
| wdt_evt | input | 1 | Single-cycle pulse: watchdog underflow caused a reset |
| cpu_hold_rst | output | 1 | Holds the main processor in reset while high |

## Verification
The collisions of interest are a reset event and a software clearing write landing on the same flag in one cycle, and a watchdog set meeting an external-reset auto-clear. The bench provokes both by driving the event pulse and the bus write on the same clock edge, once with por_evt against a write of all zeros and once with wdt_evt against a zero write and against ext_evt. It then reads the word back and requires the event to have won (R3, R5). The expected word is built from the requirement rules, so a design that lets the clear win shows a missing bit in the read-back.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int NFLAG    = 3;
  localparam int FLG_WDF  = 0;
  localparam int FLG_ERF  = 1;
  localparam int FLG_POF  = 2;

  localparam int HOLD_BIT = 3;
  localparam int MIN_DW   = 6;

  function automatic int flag_bit(input int idx);
    case (idx)
      FLG_WDF: flag_bit = 2;
      FLG_ERF: flag_bit = 4;
      default: flag_bit = 5;
    endcase
  endfunction

endpackage

// File: rtl/rcs_sticky_bit.sv
module rcs_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_en;
  logic q_nxt;

  // set outranks any clear in the same cycle
  always_comb begin
    q_en  = set_i | clr_i;
    q_nxt = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
    end else if (q_en) begin
      q_o <= q_nxt;
    end
  end

endmodule

// File: rtl/rcs_flag_bank.sv
module rcs_flag_bank
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             por_rst_n,
  input  logic [NFLAG-1:0] set_evt,
  input  logic [NFLAG-1:0] auto_clr,
  input  logic [NFLAG-1:0] bus_clr,
  output logic [NFLAG-1:0] flag_q
);

  logic [NFLAG-1:0] clr_any;

  always_comb begin
    clr_any = auto_clr | bus_clr;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    rcs_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (por_rst_n),
      .set_i (set_evt[g]),
      .clr_i (clr_any[g]),
      .q_o   (flag_q[g])
    );
  end

endmodule

// File: rtl/rcs_hold_ctl.sv
module rcs_hold_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic val_i,
  output logic hold_o
);

  logic hold_en;
  logic hold_nxt;

  always_comb begin
    hold_en  = wr_i;
    hold_nxt = val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_o <= 1'b0;
    end else if (hold_en) begin
      hold_o <= hold_nxt;
    end
  end

endmodule

// File: rtl/rcs_bus_if.sv
module rcs_bus_if
  import rcs_pkg::*;
#(
  parameter int               ADDR_W  = 8,
  parameter int               DATA_W  = 16,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NFLAG-1:0]  flags_i,
  input  logic              hold_i,
  output logic              wr_hit_o,
  output logic [NFLAG-1:0]  clr_o,
  output logic              hold_val_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << 5) | (1 << 4) | (1 << HOLD_BIT) | (1 << 2));

  logic              addr_hit;
  logic              rd_acc;
  logic [DATA_W-1:0] reg_view;
  logic [DATA_W-1:0] rd_nxt;
  logic              unused_wbits;

  always_comb begin
    addr_hit   = (bus_addr == REG_OFS);
    wr_hit_o   = bus_sel & bus_wr & addr_hit;
    rd_acc     = bus_sel & ~bus_wr;
    hold_val_o = bus_wdata[HOLD_BIT];
    for (int i = 0; i < NFLAG; i++) begin
      clr_o[i] = wr_hit_o & ~bus_wdata[flag_bit(i)];
    end
  end

  always_comb begin
    reg_view = '0;
    for (int i = 0; i < NFLAG; i++) begin
      reg_view[flag_bit(i)] = flags_i[i];
    end
    reg_view[HOLD_BIT] = hold_i;
    rd_nxt = addr_hit ? (reg_view & USED_MASK) : '0;
  end

  assign unused_wbits = ^(bus_wdata & ~USED_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (rd_acc) begin
      rdata_o <= rd_nxt;
    end
  end

endmodule

// File: rtl/rcs_reset_cause.sv
module rcs_reset_cause
  import rcs_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 16,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h18
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              blk_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              por_evt,
  input  logic              ext_evt,
  input  logic              wdt_evt,
  output logic              cpu_hold_rst
);

  logic              blk_rst_all_n;
  logic [NFLAG-1:0]  set_evt;
  logic [NFLAG-1:0]  auto_clr;
  logic [NFLAG-1:0]  bus_clr;
  logic [NFLAG-1:0]  flag_q;
  logic              wr_hit;
  logic              hold_val;
  logic              hold_q;

  if (DATA_W < MIN_DW) begin : g_bad_width
    initial $error("DATA_W too small for the flag layout");
  end

  always_comb begin
    blk_rst_all_n     = por_rst_n & blk_rst_n;
    set_evt           = '0;
    set_evt[FLG_POF]  = por_evt;
    set_evt[FLG_ERF]  = por_evt | ext_evt;
    set_evt[FLG_WDF]  = wdt_evt;
    auto_clr          = '0;
    auto_clr[FLG_WDF] = por_evt | ext_evt;
  end

  rcs_bus_if #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_OFS (REG_OFS)
  ) u_bus (
    .clk        (clk),
    .rst_n      (blk_rst_all_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .flags_i    (flag_q),
    .hold_i     (hold_q),
    .wr_hit_o   (wr_hit),
    .clr_o      (bus_clr),
    .hold_val_o (hold_val),
    .rdata_o    (bus_rdata)
  );

  rcs_flag_bank u_flags (
    .clk       (clk),
    .por_rst_n (por_rst_n),
    .set_evt   (set_evt),
    .auto_clr  (auto_clr),
    .bus_clr   (bus_clr),
    .flag_q    (flag_q)
  );

  rcs_hold_ctl u_hold (
    .clk    (clk),
    .rst_n  (blk_rst_all_n),
    .wr_i   (wr_hit),
    .val_i  (hold_val),
    .hold_o (hold_q)
  );

  assign cpu_hold_rst = hold_q;

endmodule

// File: rtl/rcs_checker.sv
module rcs_checker
  import rcs_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 16,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h18
) (
  input logic              clk,
  input logic              por_rst_n,
  input logic              blk_rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              por_evt,
  input logic              ext_evt,
  input logic              wdt_evt,
  input logic              cpu_hold_rst,
  input logic [NFLAG-1:0]  flag_q
);

  logic wr_seen;
  logic no_evt;

  assign wr_seen = bus_sel && bus_wr && (bus_addr == REG_OFS);
  assign no_evt  = !por_evt && !ext_evt && !wdt_evt;

  // R2: power-on marks both bits
  a_r2_por_sets_both: assert property (@(posedge clk) disable iff (!por_rst_n)
    por_evt |=> (flag_q[FLG_POF] && flag_q[FLG_ERF]));

  // R2: pin reset leaves the power-on flag
  a_r2_ext_keeps_pof: assert property (@(posedge clk) disable iff (!por_rst_n)
    (ext_evt && !por_evt && !wr_seen) |=> (flag_q[FLG_POF] == $past(flag_q[FLG_POF])));

  // R3: watchdog set, cleared by pin reset
  a_r3_wdt_sets: assert property (@(posedge clk) disable iff (!por_rst_n)
    wdt_evt |=> flag_q[FLG_WDF]);

  a_r3_pin_clears_wdt: assert property (@(posedge clk) disable iff (!por_rst_n)
    ((ext_evt || por_evt) && !wdt_evt) |=> !flag_q[FLG_WDF]);

  // R4: bus never raises a flag
  a_r4_no_bus_set: assert property (@(posedge clk) disable iff (!por_rst_n)
    (no_evt && flag_q == '0) |=> (flag_q == '0));

  // R5: set beats clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!por_rst_n)
    (wr_seen && bus_wdata[5] == 1'b0 && por_evt) |=> flag_q[FLG_POF]);

  // R6: hold bit follows the written value
  a_r6_hold_write: assert property (@(posedge clk) disable iff (!por_rst_n || !blk_rst_n)
    wr_seen |=> (cpu_hold_rst == $past(bus_wdata[HOLD_BIT])));

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!por_rst_n || !blk_rst_n)
    !wr_seen |=> $stable(cpu_hold_rst));

  // R7: block reset forces the hold output low
  a_r7_hold_low_in_reset: assert property (@(posedge clk)
    !blk_rst_n |-> !cpu_hold_rst);

endmodule

bind rcs_reset_cause rcs_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .REG_OFS (REG_OFS)
) u_chk (
  .clk          (clk),
  .por_rst_n    (por_rst_n),
  .blk_rst_n    (blk_rst_n),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .por_evt      (por_evt),
  .ext_evt      (ext_evt),
  .wdt_evt      (wdt_evt),
  .cpu_hold_rst (cpu_hold_rst),
  .flag_q       (flag_q)
);

// File: tb/rcs_reset_cause_bench.sv
`timescale 1ns/1ps
module rcs_reset_cause_bench;

  localparam int          AW  = 8;
  localparam int          DW  = 16;
  localparam logic [7:0]  OFS = 8'h18;

  logic          clk = 1'b0;
  logic          por_rst_n, blk_rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          por_evt, ext_evt, wdt_evt;
  logic          cpu_hold_rst;

  always #4 clk = ~clk;

  rcs_reset_cause u_rcs_reset_cause (
    .clk(clk), .por_rst_n(por_rst_n), .blk_rst_n(blk_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .por_evt(por_evt), .ext_evt(ext_evt), .wdt_evt(wdt_evt),
    .cpu_hold_rst(cpu_hold_rst)
  );

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t sb[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  logic  rd_seen;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: a read sampled at a rising edge is judged at the next falling edge
  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (sb.size() == 0) begin
        chk("SB unexpected read", bus_rdata, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic idle();
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    por_evt = 0; ext_evt = 0; wdt_evt = 0;
  endtask

  task automatic step(input logic s, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic p, input logic e, input logic t);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    por_evt = p; ext_evt = e; wdt_evt = t;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
    step(1, 0, a, '0, 0, 0, 0);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    step(1, 1, OFS, d, 0, 0, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    idle();
    por_rst_n = 0;
    blk_rst_n = 0;
    repeat (3) @(negedge clk);
    por_rst_n = 1;
    blk_rst_n = 1;
    @(negedge clk);

    chk("R1 hold after reset", DW'(cpu_hold_rst), '0);
    rd(OFS, 16'h0000, "R1 read after reset");

    step(0, 0, '0, '0, 1, 0, 0);
    rd(OFS, 16'h0030, "R2 cold start 11");

    wr(16'hFFFF);
    chk("R6 hold set", DW'(cpu_hold_rst), 16'h1);
    rd(OFS, 16'h0038, "R4 R8 ones keep flags, unused bits read 0");

    wr(16'h0008);
    rd(OFS, 16'h0008, "R4 zero clears flags");

    step(0, 0, '0, '0, 0, 1, 0);
    rd(OFS, 16'h0018, "R2 pin reset sets bit 4 only");

    step(0, 0, '0, '0, 0, 0, 1);
    rd(OFS, 16'h001C, "R3 watchdog sets bit 2");

    step(0, 0, '0, '0, 0, 1, 0);
    rd(OFS, 16'h0018, "R3 pin reset clears bit 2");

    step(0, 0, '0, '0, 0, 1, 1);
    rd(OFS, 16'h001C, "R3 watchdog beats pin clear");

    step(1, 1, OFS, 16'h0000, 0, 0, 1);
    chk("R6 hold released", DW'(cpu_hold_rst), '0);
    rd(OFS, 16'h0004, "R5 watchdog beats clearing write");

    step(1, 1, OFS + 8'h01, 16'h0008, 0, 0, 0);
    chk("R8 other address no hold", DW'(cpu_hold_rst), '0);
    rd(OFS, 16'h0004, "R8 other address write ignored");
    rd(OFS + 8'h01, 16'h0000, "R8 other address reads 0");

    rd(OFS, 16'h0004, "R9 first read");
    rd(OFS, 16'h0004, "R9 repeat read unchanged");
    @(negedge clk);
    chk("R9 rdata held", bus_rdata, 16'h0004);

    wr(16'h003C);
    chk("R6 hold set again", DW'(cpu_hold_rst), 16'h1);
    blk_rst_n = 0;
    @(negedge clk);
    chk("R7 hold low in block reset", DW'(cpu_hold_rst), '0);
    blk_rst_n = 1;
    @(negedge clk);
    rd(OFS, 16'h0004, "R7 flags kept, bit 3 cleared");

    step(1, 1, OFS, 16'h0000, 1, 0, 0);
    rd(OFS, 16'h0030, "R5 power-on beats clearing write");

    por_rst_n = 0;
    blk_rst_n = 0;
    @(negedge clk);
    por_rst_n = 1;
    blk_rst_n = 1;
    @(negedge clk);
    rd(OFS, 16'h0000, "R1 power-on reset clears all");

    @(negedge clk);
    chk("SB drained", DW'(sb.size()), '0);
    summary();
    $finish;
  end

endmodule